// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Bridge

This block turns a plain bus load into a serial flash read. A read whose address falls inside a fixed window of the address map is accepted and played out on the flash pins in a fixed order. First comes the read opcode, then the address bytes, then an optional run of dummy clocks. The requested data bytes are then captured and returned as a single bus response. One setup word describes the whole flash protocol. It sets the opcode, the address length, the dummy length, and whether data returns on one line or on four. Any load in the window therefore becomes a well-formed single-line or quad-line flash read, with no software involved per access.

The flash clock, the chip selects and the data lines are shared with a separate command-driven engine. A mode word grants the pins to this bridge. While the mode bit is clear, the pins follow the command engine and window reads are refused. When the mode bit is set during a command frame, the hand-over waits until that frame has ended. Memory-mapped writes, caching and prefetch are outside this block.

Top module: `mmap_flash_reader`

## Requirements
- R1: While reset is held and after it ends, the flash pins copy the command engine: `flash_sclk`=`cmd_sclk`, `flash_cs_n`=`cmd_cs_n`, `flash_io_out[0]`=`cmd_mosi` with `flash_io_oe`=4'b0001, and `rd_ack` is low.
- R2: A read is answered with `rd_err`=1 and `rd_data`=0, and no chip select is asserted, when mode bit 0 (register select 0) is clear. The response is a one-cycle `rd_ack` in the cycle after the request is accepted.
- R3: With the mode bit set, a read whose address bits above `WIN_BITS` differ from `WIN_BASE` gets an error response and asserts no chip select.
- R4: Every flash read starts with the 8-bit opcode from setup bits [7:0], sent MSB first on `flash_io_out[0]`.
- R5: The opcode is followed by N address bytes, where N is 1 plus setup bits [9:8]. They carry the low 8·N bits of the zero-extended window offset, MSB first, on line 0.
- R6: The number of dummy clocks is 8 × setup[11:10] + setup[31:24]. The total number of flash clock rising edges in a read is 8 + 8·N + dummy + data clocks.
- R7: When setup[13:12]=3, data is sampled as nibbles on `flash_io_in[3:0]` (first nibble is the high nibble), using 2 clocks per byte, and `flash_io_oe` is 0 during dummy and data. With any other value, data is sampled MSB first on `flash_io_in[1]`, using 8 clocks per byte.
- R8: `rd_size`+1 bytes are read. The first byte received lands in `rd_data[7:0]`, later bytes go to higher lanes, and unused lanes read 0. `rd_ack` lasts exactly one cycle.
- R9: The chip select numbered by mode bits [2:1] (active low) is the only one asserted, from the start of the opcode through the last data clock. It is deasserted by the time `rd_ack` rises, and each read asserts it once.
- R10: While `cmd_busy` is high, setting the mode bit leaves the pins with the command engine, and a window read is held without response. Once `cmd_busy` falls, the read proceeds normally.
- R11: Clearing the mode bit hands the pins back to the command engine once the bridge is idle.
- R12: The flash clock idles low and has a period of exactly two system clock cycles during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mode word, 1 the setup word |
| reg_wdata | input | 32 | Register write data |
| rd_req | input | 1 | Bus read request, held until `rd_ack` |
| rd_addr | input | ADDR_W | Bus read byte address |
| rd_size | input | 2 | Bytes to read minus one |
| rd_ack | output | 1 | One-cycle read response strobe |
| rd_err | output | 1 | Error flag qualifying `rd_ack` |
| rd_data | output | 32 | Read data, little-endian |
| cmd_busy | input | 1 | Command engine is inside a frame |
| cmd_sclk | input | 1 | Command engine flash clock |
| cmd_cs_n | input | NUM_CS | Command engine chip selects |
| cmd_mosi | input | 1 | Command engine serial output |
| flash_sclk | output | 1 | Flash clock pin |
| flash_cs_n | output | NUM_CS | Flash chip select pins, active low |
| flash_io_out | output | 4 | Flash data line outputs |
| flash_io_oe | output | 4 | Flash data line output enables |
| flash_io_in | input | 4 | Flash data line inputs |

## Verification
A wrong bit counter or phase step inside the sequencer shows at the flash pins within the same read. The opcode or address captured by the flash model shifts, or the count of clock edges under the chip select is wrong, and this is visible before `rd_ack` returns. A fault in the byte reassembly shows only in `rd_data`, at the response of that same read. A fault in pin ownership shows within a cycle or two of a mode write, or of `cmd_busy` falling, as pins that fail to follow the command engine.

// File: rtl/mmfr_pkg.sv
// Shared types for the memory-mapped flash read bridge.
// Assumes: a 32-bit setup word laid out as the setup_t struct below.
package mmfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_DUM,
        ST_DAT,
        ST_RSP
    } seq_state_t;

    typedef struct packed {
        logic [7:0] xdummy;     // extra dummy clocks
        logic [7:0] wr_op;      // write opcode, held only
        logic [1:0] rsv;
        logic [1:0] lines;      // 3 = quad data
        logic [1:0] dum_bytes;  // dummy bytes of 8 clocks
        logic [1:0] adr_field;  // address bytes minus one
        logic [7:0] rd_op;      // read opcode
    } setup_t;

    localparam logic [31:0] SETUP_RESET = 32'h0002_0203;
    localparam logic [1:0]  LINES_QUAD  = 2'd3;

endpackage

// File: rtl/mmfr_regs.sv
// Holds the mode word and the setup word.
// Assumes: writes take effect on the next edge; no read-back is provided.
module mmfr_regs
    import mmfr_pkg::*;
#(
    parameter int CS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic            reg_sel,
    input  logic [31:0]     reg_wdata,
    output logic            mm_enable,
    output logic [CS_W-1:0] mm_cs_idx,
    output setup_t          setup
);

    logic [CS_W:0] mode_q;
    setup_t        setup_q;

    // Capture register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            setup_q <= setup_t'(SETUP_RESET);
        end else if (reg_we) begin
            if (reg_sel) setup_q <= setup_t'(reg_wdata);
            else         mode_q  <= reg_wdata[CS_W:0];
        end
    end

    assign mm_enable = mode_q[0];
    assign mm_cs_idx = mode_q[CS_W:1];
    assign setup     = setup_q;

endmodule

// File: rtl/mmfr_seq.sv
// Plays out one flash read: opcode, address, dummy clocks, data, response.
// Assumes: start is only raised while idle; one flash bit spans two clk
// cycles (sclk low, then high); inputs are sampled at the end of the high half.
module mmfr_seq
    import mmfr_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2,
    parameter int OFS_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_err,
    input  logic [OFS_W-1:0]  offset,
    input  logic [1:0]        size,
    input  setup_t            setup,
    input  logic [CS_W-1:0]   cs_idx,
    input  logic [3:0]        io_in,
    output logic              idle,
    output logic              sclk,
    output logic [NUM_CS-1:0] cs_n,
    output logic              mosi,
    output logic [3:0]        io_oe,
    output logic              ack,
    output logic              err,
    output logic [31:0]       data
);

    localparam int CNT_W = $clog2(3 * 8 + 256);

    seq_state_t        state;
    logic              phase;
    logic [CNT_W-1:0]  cnt;
    logic [31:0]       shreg;
    logic [31:0]       acc;
    logic              cs_on;
    logic              err_q;
    setup_t            cfg_q;
    logic [1:0]        size_q;
    logic [CS_W-1:0]   cs_q;
    logic [OFS_W-1:0]  adr_q;

    logic              quad;
    logic [5:0]        adr_bits;
    logic [CNT_W-1:0]  dum_clks;
    logic [CNT_W-1:0]  dat_clks;
    logic [2:0]        nbytes;
    logic [1:0]        sh_bytes;
    logic [31:0]       adr_word;

    // Derive phase lengths from the captured setup.
    always_comb begin
        quad     = (cfg_q.lines == LINES_QUAD);
        adr_bits = 6'(({4'b0, cfg_q.adr_field} + 6'd1) << 3);
        dum_clks = CNT_W'({cfg_q.dum_bytes, 3'b000}) + CNT_W'(cfg_q.xdummy);
        nbytes   = {1'b0, size_q} + 3'd1;
        dat_clks = quad ? CNT_W'({nbytes, 1'b0}) : CNT_W'({nbytes, 3'b000});
        sh_bytes = 2'd3 - cfg_q.adr_field;
        adr_word = 32'(adr_q) << {sh_bytes, 3'b000};
    end

    // Sequence state, bit timing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            phase  <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
            acc    <= '0;
            cs_on  <= 1'b0;
            err_q  <= 1'b0;
            cfg_q  <= setup_t'(SETUP_RESET);
            size_q <= '0;
            cs_q   <= '0;
            adr_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        acc    <= '0;
                        size_q <= size;
                        if (start_err) begin
                            err_q <= 1'b1;
                            state <= ST_RSP;
                        end else begin
                            err_q <= 1'b0;
                            cfg_q <= setup;
                            cs_q  <= cs_idx;
                            adr_q <= offset;
                            cs_on <= 1'b1;
                            phase <= 1'b0;
                            shreg <= {setup.rd_op, 24'h0};
                            cnt   <= CNT_W'(7);
                            state <= ST_OPC;
                        end
                    end
                end
                ST_RSP: begin
                    err_q <= 1'b0;
                    state <= ST_IDLE;
                end
                default: begin
                    if (!phase) begin
                        phase <= 1'b1;
                    end else begin
                        phase <= 1'b0;
                        shreg <= shreg << 1;
                        if (state == ST_DAT)
                            acc <= quad ? {acc[27:0], io_in} : {acc[30:0], io_in[1]};
                        if (cnt != '0) begin
                            cnt <= cnt - 1'b1;
                        end else begin
                            case (state)
                                ST_OPC: begin
                                    state <= ST_ADR;
                                    shreg <= adr_word;
                                    cnt   <= CNT_W'(adr_bits) - 1'b1;
                                end
                                ST_ADR: begin
                                    if (dum_clks != '0) begin
                                        state <= ST_DUM;
                                        cnt   <= dum_clks - 1'b1;
                                    end else begin
                                        state <= ST_DAT;
                                        cnt   <= dat_clks - 1'b1;
                                    end
                                end
                                ST_DUM: begin
                                    state <= ST_DAT;
                                    cnt   <= dat_clks - 1'b1;
                                end
                                default: begin
                                    cs_on <= 1'b0;
                                    state <= ST_RSP;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // Reorder captured bytes little-endian and blank unused lanes.
    always_comb begin
        data = '0;
        if (!err_q) begin
            for (int i = 0; i < 4; i++) begin
                if (i <= int'(size_q))
                    data[i*8 +: 8] = acc[(int'(size_q) - i)*8 +: 8];
            end
        end
    end

    // Drive pins and response from the sequence state.
    always_comb begin
        idle = (state == ST_IDLE);
        sclk = phase;
        mosi = shreg[31];
        cs_n = cs_on ? ~(NUM_CS'(1) << cs_q) : '1;
        if ((state == ST_DUM || state == ST_DAT) && quad) io_oe = 4'b0000;
        else                                              io_oe = 4'b0001;
        ack  = (state == ST_RSP);
        err  = err_q;
    end

endmodule

// File: rtl/mmfr_pinmux.sv
// Decides who owns the flash pins and muxes them.
// Assumes: ownership moves to the bridge only between command frames, and
// back to the command engine only while the sequencer is idle.
module mmfr_pinmux #(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mm_enable,
    input  logic              cmd_busy,
    input  logic              seq_idle,
    input  logic              seq_sclk,
    input  logic [NUM_CS-1:0] seq_cs_n,
    input  logic              seq_mosi,
    input  logic [3:0]        seq_oe,
    input  logic              cmd_sclk,
    input  logic [NUM_CS-1:0] cmd_cs_n,
    input  logic              cmd_mosi,
    output logic              owner_mm,
    output logic              pin_sclk,
    output logic [NUM_CS-1:0] pin_cs_n,
    output logic [3:0]        pin_io_out,
    output logic [3:0]        pin_io_oe
);

    // Track pin ownership.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      owner_mm <= 1'b0;
        else if (!owner_mm && mm_enable && !cmd_busy)    owner_mm <= 1'b1;
        else if (owner_mm && !mm_enable && seq_idle)     owner_mm <= 1'b0;
    end

    // Select the pin source.
    always_comb begin
        if (owner_mm) begin
            pin_sclk   = seq_sclk;
            pin_cs_n   = seq_cs_n;
            pin_io_out = {3'b000, seq_mosi};
            pin_io_oe  = seq_oe;
        end else begin
            pin_sclk   = cmd_sclk;
            pin_cs_n   = cmd_cs_n;
            pin_io_out = {3'b000, cmd_mosi};
            pin_io_oe  = 4'b0001;
        end
    end

endmodule

// File: rtl/mmap_flash_reader.sv
// Top of the memory-mapped flash read bridge: window decode, acceptance,
// register block, sequencer and pin mux.
// Assumes: rd_req is held until rd_ack and dropped in the ack cycle;
// NUM_CS is at least 2; WIN_BITS is at most 32.
module mmap_flash_reader
    import mmfr_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              WIN_BITS = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h3000_0000,
    parameter int              NUM_CS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_size,
    output logic              rd_ack,
    output logic              rd_err,
    output logic [31:0]       rd_data,
    input  logic              cmd_busy,
    input  logic              cmd_sclk,
    input  logic [NUM_CS-1:0] cmd_cs_n,
    input  logic              cmd_mosi,
    output logic              flash_sclk,
    output logic [NUM_CS-1:0] flash_cs_n,
    output logic [3:0]        flash_io_out,
    output logic [3:0]        flash_io_oe,
    input  logic [3:0]        flash_io_in
);

    localparam int CS_W = $clog2(NUM_CS);

    logic              mm_enable;
    logic [CS_W-1:0]   mm_cs_idx;
    setup_t            setup;
    logic              owner_mm;
    logic              in_win;
    logic              start;
    logic              start_err;
    logic              seq_idle;
    logic              seq_sclk;
    logic [NUM_CS-1:0] seq_cs_n;
    logic              seq_mosi;
    logic [3:0]        seq_oe;

    // Decode the window and decide whether a request may start.
    always_comb begin
        in_win    = (rd_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
        start_err = !mm_enable || !in_win;
        start     = seq_idle && rd_req && (start_err || owner_mm);
    end

    mmfr_regs #(.CS_W(CS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .mm_enable (mm_enable),
        .mm_cs_idx (mm_cs_idx),
        .setup     (setup)
    );

    mmfr_seq #(.NUM_CS(NUM_CS), .CS_W(CS_W), .OFS_W(WIN_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_err (start_err),
        .offset    (rd_addr[WIN_BITS-1:0]),
        .size      (rd_size),
        .setup     (setup),
        .cs_idx    (mm_cs_idx),
        .io_in     (flash_io_in),
        .idle      (seq_idle),
        .sclk      (seq_sclk),
        .cs_n      (seq_cs_n),
        .mosi      (seq_mosi),
        .io_oe     (seq_oe),
        .ack       (rd_ack),
        .err       (rd_err),
        .data      (rd_data)
    );

    mmfr_pinmux #(.NUM_CS(NUM_CS)) u_pinmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .mm_enable  (mm_enable),
        .cmd_busy   (cmd_busy),
        .seq_idle   (seq_idle),
        .seq_sclk   (seq_sclk),
        .seq_cs_n   (seq_cs_n),
        .seq_mosi   (seq_mosi),
        .seq_oe     (seq_oe),
        .cmd_sclk   (cmd_sclk),
        .cmd_cs_n   (cmd_cs_n),
        .cmd_mosi   (cmd_mosi),
        .owner_mm   (owner_mm),
        .pin_sclk   (flash_sclk),
        .pin_cs_n   (flash_cs_n),
        .pin_io_out (flash_io_out),
        .pin_io_oe  (flash_io_oe)
    );

endmodule

// File: rtl/mmfr_checker.sv
// Temporal checks on the flash read bridge, bound to its top module.
// Assumes: owner_mm is the pin ownership flag inside the top.
module mmfr_checker #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              owner_mm,
    input logic              cmd_busy,
    input logic [NUM_CS-1:0] flash_cs_n,
    input logic              flash_sclk,
    input logic              rd_ack,
    input logic              rd_err,
    input logic [31:0]       rd_data
);

    assert_err_zero_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && rd_err |-> rd_data == 32'h0);

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !rd_ack);

    assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        owner_mm |-> $onehot0(~flash_cs_n));

    assert_released_at_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        owner_mm && rd_ack |-> &flash_cs_n);

    assert_no_grab_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy && !owner_mm |=> !owner_mm);

    assert_sclk_idle_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        owner_mm && (&flash_cs_n) |-> !flash_sclk);

endmodule

bind mmap_flash_reader mmfr_checker #(.NUM_CS(NUM_CS)) u_mmfr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .owner_mm   (owner_mm),
    .cmd_busy   (cmd_busy),
    .flash_cs_n (flash_cs_n),
    .flash_sclk (flash_sclk),
    .rd_ack     (rd_ack),
    .rd_err     (rd_err),
    .rd_data    (rd_data)
);

// File: tb/test_mmap_flash_reader.sv
module test_mmap_flash_reader;

    localparam logic [31:0] BASE = 32'h3000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        rd_req = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [1:0]  rd_size = '0;
    logic        rd_ack;
    logic        rd_err;
    logic [31:0] rd_data;
    logic        cmd_busy = 1'b0;
    logic        cmd_sclk = 1'b1;
    logic [3:0]  cmd_cs_n = 4'b1011;
    logic        cmd_mosi = 1'b1;
    logic        flash_sclk;
    logic [3:0]  flash_cs_n;
    logic [3:0]  flash_io_out;
    logic [3:0]  flash_io_oe;
    logic [3:0]  fio = 4'h0;

    int n_vec = 0;
    int n_bad = 0;

    // flash model state
    int         seed = 0;
    bit         cfg_quad = 0;
    int         cfg_abytes = 3;
    int         rises = 0;
    int         cs_falls = 0;
    int         bad_period = 0;
    longint     last_rise = 0;
    logic [7:0] op_cap = '0;
    logic [31:0] adr_cap = '0;
    logic [3:0] cs_seen = 4'hF;
    logic [3:0] prev_cs = 4'hF;
    logic       prev_sclk = 1'b0;

    always #2 clk = ~clk;

    mmap_flash_reader i_mmap_flash_reader (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_size(rd_size), .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
        .cmd_busy(cmd_busy), .cmd_sclk(cmd_sclk), .cmd_cs_n(cmd_cs_n),
        .cmd_mosi(cmd_mosi), .flash_sclk(flash_sclk), .flash_cs_n(flash_cs_n),
        .flash_io_out(flash_io_out), .flash_io_oe(flash_io_oe),
        .flash_io_in(fio)
    );

    function automatic logic fbit(int k);
        return 1'(((k * k * 7 + k * 3 + seed) >> 2) & 1);
    endfunction

    function automatic logic [3:0] gnib(int k);
        return 4'((k * k + k * 5 + seed * 3) & 15);
    endfunction

    function automatic logic [3:0] drive_val(int k);
        if (cfg_quad) return gnib(k);
        return {2'b01, fbit(k), 1'b0};
    endfunction

    // Flash model: captures line 0 at rising sclk, drives data after falling sclk.
    always @(posedge flash_sclk or negedge flash_sclk or flash_cs_n) begin
        #1;
        if (flash_cs_n != prev_cs) begin
            if (flash_cs_n != 4'hF) begin
                rises = 0; op_cap = '0; adr_cap = '0; bad_period = 0;
                cs_seen = flash_cs_n; cs_falls++;
                fio = drive_val(0);
            end
            prev_cs = flash_cs_n;
        end else if (flash_sclk && !prev_sclk && flash_cs_n != 4'hF) begin
            if (rises > 0 && ($time - last_rise) != 8) bad_period++;
            last_rise = $time;
            if (rises < 8) op_cap = {op_cap[6:0], flash_io_out[0]};
            else if (rises < 8 + 8 * cfg_abytes) adr_cap = {adr_cap[30:0], flash_io_out[0]};
            rises++;
        end else if (!flash_sclk && prev_sclk) begin
            fio = drive_val(rises);
        end
        prev_sclk = flash_sclk;
    end

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(bit sel, logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_read(logic [31:0] a, logic [1:0] s, output bit got,
                           output logic [31:0] d, output logic e);
        got = 0; d = '0; e = 1'b0;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a; rd_size = s;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rd_ack) begin got = 1; d = rd_data; e = rd_err; break; end
        end
        rd_req = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_data(int d0, bit q, int sz);
        logic [31:0] r = '0;
        for (int j = 0; j <= sz; j++) begin
            if (q) begin
                r[j*8+4 +: 4] = gnib(d0 + 2 * j);
                r[j*8 +: 4]   = gnib(d0 + 2 * j + 1);
            end else begin
                for (int b = 0; b < 8; b++) r[j*8 + b] = fbit(d0 + 8 * j + 7 - b);
            end
        end
        return r;
    endfunction

    // One full read with every per-read check.
    task automatic run_read(int fld, int dum, int xd, bit q, int sz, int cs, int it);
        logic [31:0] setup, addr, d, mask;
        logic [7:0]  op;
        logic        e;
        bit          got;
        int          dclk, d0, total;
        op = q ? 8'h6B : (dum != 0 ? 8'h0B : 8'h03);
        setup = {8'(xd), 8'h02, 2'b00, q ? 2'b11 : 2'b00, 2'(dum), 2'(fld), op};
        wr_reg(1'b1, setup);
        wr_reg(1'b0, {29'd0, 2'(cs), 1'b1});
        seed = it; cfg_quad = q; cfg_abytes = fld + 1;
        addr = BASE | ((32'(it) * 32'h009E_3779 + 32'h5A3C71) & 32'h00FF_FFFF);
        do_read(addr, 2'(sz), got, d, e);
        dclk = 8 * dum + xd;
        d0 = 8 + 8 * (fld + 1) + dclk;
        total = d0 + (q ? 2 : 8) * (sz + 1);
        mask = (fld == 3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (fld + 1))) - 1);
        check(got && !e, "R9", {got, e}, 2'b10);
        check(op_cap == op, "R4", op_cap, op);
        check(adr_cap == (addr & 32'h00FF_FFFF & mask), "R5", adr_cap, addr & 32'h00FF_FFFF & mask);
        check(rises == total, "R6", rises, total);
        check(d == exp_data(d0, q, sz), q ? "R7 quad R8" : "R7 single R8", d, exp_data(d0, q, sz));
        check(cs_seen == ~(4'h1 << cs), "R9", cs_seen, ~(4'h1 << cs));
        check(bad_period == 0, "R12", bad_period, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        e;
        bit          got;
        int          it, f0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(flash_cs_n == cmd_cs_n && flash_sclk == cmd_sclk && !rd_ack, "R1 in reset",
              {flash_cs_n, flash_sclk, rd_ack}, {cmd_cs_n, cmd_sclk, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        check(flash_io_out[0] == cmd_mosi && flash_io_oe == 4'b0001 && flash_cs_n == cmd_cs_n,
              "R1 after reset", {flash_io_out, flash_io_oe}, {4'b0001, 4'b0001});
        cmd_sclk = 1'b0; cmd_cs_n = 4'hF; cmd_mosi = 1'b0;
        @(negedge clk);

        // R2: mode clear -> error response, no select
        f0 = cs_falls;
        do_read(BASE + 32'h10, 2'd3, got, d, e);
        check(got && e && d == 0, "R2", {got, e, d}, {2'b11, 32'h0});
        check(cs_falls == f0, "R2 no select", cs_falls, f0);

        // main sweep
        it = 0;
        for (int fld = 0; fld < 4; fld++)
            for (int dum = 0; dum < 3; dum++)
                for (int q = 0; q < 2; q++)
                    for (int sz = 0; sz < 4; sz++) begin
                        run_read(fld, dum, 0, q[0], sz, (fld + sz + q) % 4, it);
                        it++;
                    end

        // R6: extra dummy clocks
        run_read(2, 1, 5, 1'b1, 3, 2, 501);
        run_read(1, 0, 3, 1'b0, 1, 1, 502);

        // R3: out-of-window read
        f0 = cs_falls;
        do_read(32'h3100_0004, 2'd0, got, d, e);
        check(got && e && d == 0, "R3", {got, e, d}, {2'b11, 32'h0});
        check(cs_falls == f0, "R3 no select", cs_falls, f0);

        // R11: clear mode -> pins back to command engine
        wr_reg(1'b0, 32'h0);
        cmd_cs_n = 4'b0111; cmd_sclk = 1'b1; cmd_mosi = 1'b1;
        @(negedge clk);
        check(flash_cs_n == 4'b0111 && flash_sclk && flash_io_out[0] && flash_io_oe == 4'b0001,
              "R11", {flash_cs_n, flash_sclk, flash_io_out[0]}, {4'b0111, 2'b11});

        // R10: hold-off during a command frame
        cmd_busy = 1'b1;
        wr_reg(1'b1, {8'd0, 8'h02, 2'b00, 2'b00, 2'b00, 2'b10, 8'h03});
        wr_reg(1'b0, {29'd0, 2'd3, 1'b1});
        repeat (3) @(negedge clk);
        check(flash_cs_n == 4'b0111 && flash_sclk, "R10 pins kept", {flash_cs_n, flash_sclk}, {4'b0111, 1'b1});
        cmd_sclk = 1'b0; cmd_cs_n = 4'hF;
        seed = 777; cfg_quad = 0; cfg_abytes = 3;
        rd_req = 1'b1; rd_addr = BASE + 32'h00_1234; rd_size = 2'd1;
        got = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rd_ack) got = 1;
        end
        check(!got && flash_cs_n == 4'hF, "R10 held", {got, flash_cs_n}, {1'b0, 4'hF});
        cmd_busy = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rd_ack) begin got = 1; d = rd_data; e = rd_err; break; end
        end
        rd_req = 1'b0;
        @(negedge clk);
        check(got && !e && d == exp_data(32, 1'b0, 1), "R10 proceeds", d, exp_data(32, 1'b0, 1));
        check(adr_cap == 32'h00_1234 && cs_seen == 4'b0111, "R10 R5", {adr_cap, cs_seen}, {32'h1234, 4'b0111});

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule